// File: doc/BRIEF.md
# Sprite Attribute Memory Port

This block gives the host processor access to a 256-byte store of sprite attributes (64 entries of 4 bytes each). A host writes an 8-bit byte pointer through one register, then streams bytes through a data register. Each data write stores the byte at the pointer and advances the pointer by one, wrapping from 0xFF to 0x00. Data reads return the byte at the pointer only while the picture generator is idle, and they never move the pointer.

The block watches the raster dot and line counters and the two rendering-enable bits. While rendering is active, it forces the pointer to zero during the sprite fetch window. At a fixed dot of every visible line it also exports the pointer as the index where sprite evaluation starts. The pointer is exported unchanged, so an index that is not a multiple of four is passed through as it is.

A bulk-copy sequencer fills the whole store from one 256-byte page of host memory. The host writes a page number to a trigger register. The block then holds the host stalled while it performs 256 fetch/store pairs. Each pair is a read of host memory followed by a data-port style write, so the copy starts at the current pointer and leaves the pointer where it began.

Top module: `spr_mem_port`

## Requirements
- R1: After reset the pointer is 0x00, `cpu_stall`, `dma_rd_en` and `eval_start_vld` are low, and `eval_start` is 0x00.
- R2: A host write with `reg_sel` = 0 loads `reg_wdata` into the pointer at that clock edge.
- R3: A host write with `reg_sel` = 1 stores `reg_wdata` at the pointer, then advances the pointer by one. The pointer wraps from 0xFF to 0x00.
- R4: Rendering is active when `show_bg` or `show_spr` is set and `line` is 0–239 or 261. Outside rendering, a host read with `reg_sel` = 1 shows the byte at the pointer on `reg_rdata` in the same cycle and leaves the pointer unchanged.
- R5: While rendering is active, a host read with `reg_sel` = 1 returns 0xFF and leaves the pointer unchanged.
- R6: While rendering is active and `dot` is 257–320 inclusive, the pointer becomes 0x00 at each clock edge. This clear wins over a host pointer load in the same cycle.
- R7: With both enable bits clear, or on lines 240–260, dots 257–320 leave the pointer untouched.
- R8: At the edge where `dot` = 65 and `line` is 0–239, `eval_start` takes the pointer value, aligned or not, and `eval_start_vld` is high for exactly the following cycle. It is low after any other edge.
- R9: A host write with `reg_sel` = 2 and page P raises `cpu_stall` from the next cycle for exactly 512 cycles. Pair i reads address P·256+i (`dma_rd_en` high, with data expected on `dma_rd_data` one cycle later) and stores that byte at pointer+i modulo 256.
- R10: While `cpu_stall` is high, host register writes are ignored and host reads return 0x00.
- R11: After a bulk copy the pointer is back at its value from before the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_re | input | 1 | Host register read strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 copy trigger |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| dot | input | 9 | Raster dot counter, 0–340 |
| line | input | 9 | Raster line counter, 0–261 |
| show_bg | input | 1 | Background rendering enable |
| show_spr | input | 1 | Sprite rendering enable |
| dma_rd_en | output | 1 | Bulk-copy read request to host memory |
| dma_rd_addr | output | 16 | Bulk-copy read address |
| dma_rd_data | input | 8 | Host memory data, valid one cycle after the request |
| cpu_stall | output | 1 | Holds the host off during a bulk copy |
| eval_start | output | 8 | Captured evaluation start index |
| eval_start_vld | output | 1 | One-cycle pulse after each capture |

## Verification
The bench checks the pointer at its edges. It writes at 0xFF to catch a pointer that saturates or fails to wrap, and it starts a bulk copy at an unaligned pointer to catch a copy that begins at zero or leaves the pointer moved afterwards. It places single-cycle dot values at 256, 257, 320 and 321, on line 261 and on a blanked line. A window decoded one dot off, or a clear left active during blanking, shows up as a wrong captured index. Repeated reads in blank and during rendering expose a read path that advances the pointer. A host load issued in the same cycle as the forced clear checks the priority. Counting stalled cycles and checking the reads made while stalled shows whether the copy length is off by one and whether the host leaks through during the copy.

// File: rtl/spr_pkg.sv
package spr_pkg;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_COPY = 2'd2,
      SEL_NONE = 2'd3
   } spr_sel_e;

   typedef enum logic [1:0] {
      CP_IDLE  = 2'd0,
      CP_FETCH = 2'd1,
      CP_STORE = 2'd2
   } copy_state_e;

endpackage

// File: rtl/spr_raster_dec.sv
module spr_raster_dec #(
   parameter int CTR_W     = 9,
   parameter int VIS_LAST  = 239,
   parameter int PRE_LINE  = 261,
   parameter int CLR_FIRST = 257,
   parameter int CLR_LAST  = 320,
   parameter int EVAL_DOT  = 65
) (
   input  logic [CTR_W-1:0] dot,
   input  logic [CTR_W-1:0] line,
   input  logic             show_bg,
   input  logic             show_spr,
   output logic             rendering,
   output logic             clr_window,
   output logic             eval_tick
);
   localparam logic [CTR_W-1:0] VIS_L = CTR_W'(VIS_LAST);
   localparam logic [CTR_W-1:0] PRE_L = CTR_W'(PRE_LINE);
   localparam logic [CTR_W-1:0] CLR_A = CTR_W'(CLR_FIRST);
   localparam logic [CTR_W-1:0] CLR_B = CTR_W'(CLR_LAST);
   localparam logic [CTR_W-1:0] EVL_D = CTR_W'(EVAL_DOT);

   logic visible_line;
   logic active_line;
   logic any_enable;
   logic in_clr_dots;

   always_comb begin
      visible_line = (line <= VIS_L);
      active_line  = visible_line || (line == PRE_L);
      any_enable   = show_bg || show_spr;
      in_clr_dots  = (dot >= CLR_A) && (dot <= CLR_B);
      rendering    = any_enable && active_line;
      clr_window   = rendering && in_clr_dots;
      eval_tick    = visible_line && (dot == EVL_D);
   end

endmodule

// File: rtl/spr_ptr_ctrl.sv
module spr_ptr_ctrl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              capture,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] cap_val,
   output logic              cap_vld
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   // Priority: raster clear, then host load, then post-write advance.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (step) begin
         ptr <= ptr + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_val <= '0;
         cap_vld <= 1'b0;
      end else begin
         cap_vld <= capture;
         if (capture) begin
            cap_val <= ptr;
         end
      end
   end

endmodule

// File: rtl/spr_store.sv
module spr_store #(
   parameter int ENTRIES     = 64,
   parameter int ENTRY_BYTES = 4,
   parameter int DATA_W      = 8,
   localparam int DEPTH      = ENTRIES * ENTRY_BYTES,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_byte
         localparam int IDX = e * ENTRY_BYTES + b;
         logic [DATA_W-1:0] byte_q;
         always_ff @(posedge clk) begin
            if (we && (addr == ADDR_W'(IDX))) begin
               byte_q <= wdata;
            end
         end
         assign cells[IDX] = byte_q;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/spr_copy_seq.sv
module spr_copy_seq
   import spr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 8,
   parameter int DATA_W = 8,
   localparam int SYS_W = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] page,
   output logic              rd_en,
   output logic [SYS_W-1:0]  rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] LAST = '1;
   localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

   copy_state_e       state_q;
   logic [PAGE_W-1:0] page_q;
   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CP_IDLE;
         page_q  <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            CP_IDLE: begin
               if (start) begin
                  page_q  <= page;
                  idx_q   <= '0;
                  state_q <= CP_FETCH;
               end
            end
            CP_FETCH: state_q <= CP_STORE;
            CP_STORE: begin
               idx_q   <= idx_q + ONE;
               state_q <= (idx_q == LAST) ? CP_IDLE : CP_FETCH;
            end
            default: state_q <= CP_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_en   = (state_q == CP_FETCH);
      rd_addr = {page_q, idx_q};
      wr_en   = (state_q == CP_STORE);
      wr_data = rd_data;
      busy    = (state_q != CP_IDLE);
   end

endmodule

// File: rtl/spr_mem_port.sv
module spr_mem_port
   import spr_pkg::*;
#(
   parameter int ENTRIES     = 64,
   parameter int ENTRY_BYTES = 4,
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 8,
   parameter int CTR_W       = 9,
   parameter int VIS_LAST    = 239,
   parameter int PRE_LINE    = 261,
   parameter int CLR_FIRST   = 257,
   parameter int CLR_LAST    = 320,
   parameter int EVAL_DOT    = 65,
   parameter logic [DATA_W-1:0] RENDER_RD_VAL = '1,
   localparam int DEPTH      = ENTRIES * ENTRY_BYTES,
   localparam int ADDR_W     = $clog2(DEPTH),
   localparam int SYS_W      = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [CTR_W-1:0]  dot,
   input  logic [CTR_W-1:0]  line,
   input  logic              show_bg,
   input  logic              show_spr,
   output logic              dma_rd_en,
   output logic [SYS_W-1:0]  dma_rd_addr,
   input  logic [DATA_W-1:0] dma_rd_data,
   output logic              cpu_stall,
   output logic [ADDR_W-1:0] eval_start,
   output logic              eval_start_vld
);
   // Elaboration-time parameter checks
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("store depth must be a power of two");
   end
   if (ADDR_W != DATA_W) begin : g_bad_width
      $error("pointer width must equal data width");
   end
   if (PAGE_W > DATA_W) begin : g_bad_page
      $error("page number must fit in one data byte");
   end
   if (CLR_FIRST > CLR_LAST) begin : g_bad_window
      $error("clear window is empty");
   end
   if ((1 << CTR_W) <= PRE_LINE) begin : g_bad_ctr
      $error("counter width too small for the pre-render line");
   end

   spr_sel_e          sel;
   logic              host_ok;
   logic              host_ptr_wr;
   logic              host_data_wr;
   logic              host_data_rd;
   logic              copy_start;
   logic              rendering;
   logic              clr_window;
   logic              eval_tick;
   logic [ADDR_W-1:0] addr_q;
   logic              copy_wr;
   logic [DATA_W-1:0] copy_wdata;
   logic              store_we;
   logic [DATA_W-1:0] store_wdata;
   logic [DATA_W-1:0] store_rdata;

   always_comb begin
      sel          = spr_sel_e'(reg_sel);
      host_ok      = !cpu_stall;
      host_ptr_wr  = reg_we && host_ok && (sel == SEL_PTR);
      host_data_wr = reg_we && host_ok && (sel == SEL_DATA);
      copy_start   = reg_we && host_ok && (sel == SEL_COPY);
      host_data_rd = reg_re && host_ok && (sel == SEL_DATA);
      store_we     = host_data_wr || copy_wr;
      store_wdata  = copy_wr ? copy_wdata : reg_wdata;
   end

   spr_raster_dec #(
      .CTR_W    (CTR_W),
      .VIS_LAST (VIS_LAST),
      .PRE_LINE (PRE_LINE),
      .CLR_FIRST(CLR_FIRST),
      .CLR_LAST (CLR_LAST),
      .EVAL_DOT (EVAL_DOT)
   ) u_dec (
      .dot       (dot),
      .line      (line),
      .show_bg   (show_bg),
      .show_spr  (show_spr),
      .rendering (rendering),
      .clr_window(clr_window),
      .eval_tick (eval_tick)
   );

   spr_ptr_ctrl #(
      .ADDR_W(ADDR_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_window),
      .load    (host_ptr_wr),
      .load_val(reg_wdata[ADDR_W-1:0]),
      .step    (store_we),
      .capture (eval_tick),
      .ptr     (addr_q),
      .cap_val (eval_start),
      .cap_vld (eval_start_vld)
   );

   spr_store #(
      .ENTRIES    (ENTRIES),
      .ENTRY_BYTES(ENTRY_BYTES),
      .DATA_W     (DATA_W)
   ) u_store (
      .clk  (clk),
      .we   (store_we),
      .addr (addr_q),
      .wdata(store_wdata),
      .rdata(store_rdata)
   );

   spr_copy_seq #(
      .ADDR_W(ADDR_W),
      .PAGE_W(PAGE_W),
      .DATA_W(DATA_W)
   ) u_copy (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (copy_start),
      .page   (reg_wdata[PAGE_W-1:0]),
      .rd_en  (dma_rd_en),
      .rd_addr(dma_rd_addr),
      .rd_data(dma_rd_data),
      .wr_en  (copy_wr),
      .wr_data(copy_wdata),
      .busy   (cpu_stall)
   );

   always_comb begin
      if (!host_data_rd) begin
         reg_rdata = '0;
      end else if (rendering) begin
         reg_rdata = RENDER_RD_VAL;
      end else begin
         reg_rdata = store_rdata;
      end
   end

endmodule

// File: rtl/spr_mem_port_chk.sv
module spr_mem_port_chk #(
   parameter int CTR_W     = 9,
   parameter int ADDR_W    = 8,
   parameter int SYS_W     = 16,
   parameter int VIS_LAST  = 239,
   parameter int PRE_LINE  = 261,
   parameter int CLR_FIRST = 257,
   parameter int CLR_LAST  = 320,
   parameter int EVAL_DOT  = 65
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              reg_re,
   input logic [CTR_W-1:0]  dot,
   input logic [CTR_W-1:0]  line,
   input logic              show_bg,
   input logic              show_spr,
   input logic              dma_rd_en,
   input logic [SYS_W-1:0]  dma_rd_addr,
   input logic              cpu_stall,
   input logic [ADDR_W-1:0] eval_start,
   input logic              eval_start_vld,
   input logic [ADDR_W-1:0] addr_q
);
   logic past_ok;
   logic clr_cond;
   logic eval_cond;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_comb begin
      clr_cond  = (show_bg || show_spr)
                  && ((int'(line) <= VIS_LAST) || (int'(line) == PRE_LINE))
                  && (int'(dot) >= CLR_FIRST) && (int'(dot) <= CLR_LAST);
      eval_cond = (int'(line) <= VIS_LAST) && (int'(dot) == EVAL_DOT);
   end

   // R9: fetches happen only while the host is held off
   p_fetch_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rd_en |-> cpu_stall);

   // R9: a fetch is always followed by a store cycle
   p_fetch_alternates_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rd_en |=> !dma_rd_en);

   // R9: consecutive fetches of one copy step the address by one
   p_fetch_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && dma_rd_en && $past(dma_rd_en, 2) && $past(cpu_stall))
         |-> (dma_rd_addr == $past(dma_rd_addr, 2) + SYS_W'(1)));

   // R6: pointer reads zero after every edge inside the clear window
   p_clear_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_cond)) |-> (addr_q == '0));

   // R4, R5: a host read without write never moves the pointer
   p_read_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(reg_re && !reg_we && !cpu_stall && !clr_cond))
         |-> (addr_q == $past(addr_q)));

   // R8: the capture pulse follows an evaluation dot and only that
   p_eval_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (eval_start_vld == $past(eval_cond)));

   // R8: the captured index holds between pulses
   p_eval_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !eval_start_vld) |-> $stable(eval_start));

   // R1: nothing pulses out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !past_ok |-> (!cpu_stall && !dma_rd_en));

endmodule

bind spr_mem_port spr_mem_port_chk #(
   .CTR_W    (CTR_W),
   .ADDR_W   (ADDR_W),
   .SYS_W    (SYS_W),
   .VIS_LAST (VIS_LAST),
   .PRE_LINE (PRE_LINE),
   .CLR_FIRST(CLR_FIRST),
   .CLR_LAST (CLR_LAST),
   .EVAL_DOT (EVAL_DOT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_re        (reg_re),
   .dot           (dot),
   .line          (line),
   .show_bg       (show_bg),
   .show_spr      (show_spr),
   .dma_rd_en     (dma_rd_en),
   .dma_rd_addr   (dma_rd_addr),
   .cpu_stall     (cpu_stall),
   .eval_start    (eval_start),
   .eval_start_vld(eval_start_vld),
   .addr_q        (addr_q)
);

// File: tb/spr_mem_port_tb.sv
module spr_mem_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [8:0]  dot = 9'd0;
   logic [8:0]  line = 9'd250;
   logic        show_bg = 1'b0;
   logic        show_spr = 1'b0;
   logic        dma_rd_en;
   logic [15:0] dma_rd_addr;
   logic [7:0]  dma_rd_data = '0;
   logic        cpu_stall;
   logic [7:0]  eval_start;
   logic        eval_start_vld;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spr_mem_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dot(dot), .line(line), .show_bg(show_bg), .show_spr(show_spr),
      .dma_rd_en(dma_rd_en), .dma_rd_addr(dma_rd_addr),
      .dma_rd_data(dma_rd_data), .cpu_stall(cpu_stall),
      .eval_start(eval_start), .eval_start_vld(eval_start_vld)
   );

   function automatic logic [7:0] pat(input logic [15:0] a);
      return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
   endfunction

   // Host memory model: data one cycle after the request
   always @(posedge clk) if (dma_rd_en) dma_rd_data <= pat(dma_rd_addr);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk);
      reg_re = 1'b1; reg_sel = 2'd1;
      #1 v = reg_rdata;
      @(posedge clk); #1;
      reg_re = 1'b0; reg_sel = 2'd3;
   endtask

   // Pointer observed through the evaluation capture (line 3, dot 65)
   task automatic cap(output logic [7:0] v, output logic vl);
      @(negedge clk);
      line = 9'd3; dot = 9'd65;
      @(posedge clk); #1;
      v = eval_start; vl = eval_start_vld;
      line = 9'd250; dot = 9'd0;
   endtask

   task automatic t_reset();
      logic [7:0] v; logic vl;
      chk("R1 stall", cpu_stall, 0);
      chk("R1 rd_en", dma_rd_en, 0);
      chk("R1 vld", eval_start_vld, 0);
      chk("R1 eval_start", eval_start, 0);
      cap(v, vl);
      chk("R1 pointer", v, 8'h00);
   endtask

   task automatic t_write_read();
      logic [7:0] v; logic vl;
      wr(0, 8'h20);
      wr(1, 8'h11); wr(1, 8'h22); wr(1, 8'h33);
      cap(v, vl);
      chk("R3 step x3", v, 8'h23);
      wr(0, 8'h20);
      cap(v, vl);
      chk("R2 load", v, 8'h20);
      rd(v); chk("R4 read", v, 8'h11);
      rd(v); chk("R4 no step", v, 8'h11);
      wr(0, 8'h21);
      @(negedge clk); line = 9'd100;   // forced blank on a visible line
      rd(v); chk("R4 forced blank read", v, 8'h22);
      line = 9'd250;
   endtask

   task automatic t_wrap();
      logic [7:0] v; logic vl;
      wr(0, 8'hFF); wr(1, 8'hAB); wr(1, 8'hCD);
      cap(v, vl); chk("R3 wrap", v, 8'h01);
      wr(0, 8'hFF); rd(v); chk("R3 byte at FF", v, 8'hAB);
      wr(0, 8'h00); rd(v); chk("R3 byte at 00", v, 8'hCD);
   endtask

   task automatic t_render_read();
      logic [7:0] v;
      wr(0, 8'h21);
      @(negedge clk); line = 9'd100; dot = 9'd10; show_bg = 1'b1;
      rd(v); chk("R5 render read", v, 8'hFF);
      rd(v); chk("R5 render read again", v, 8'hFF);
      @(negedge clk); show_bg = 1'b0; line = 9'd250;
      rd(v); chk("R5 pointer unchanged", v, 8'h22);
   endtask

   task automatic pulse_dot(input logic [8:0] ln, input logic [8:0] dt,
                            input logic bg, input logic sp);
      @(negedge clk);
      line = ln; dot = dt; show_bg = bg; show_spr = sp;
      @(negedge clk);
      line = 9'd250; dot = 9'd0; show_bg = 1'b0; show_spr = 1'b0;
   endtask

   task automatic t_clear();
      logic [7:0] v; logic vl;
      wr(0, 8'h33); pulse_dot(9'd261, 9'd257, 1'b0, 1'b1);
      cap(v, vl); chk("R6 clear pre-render dot 257", v, 8'h00);
      wr(0, 8'h34); pulse_dot(9'd120, 9'd320, 1'b1, 1'b0);
      cap(v, vl); chk("R6 clear dot 320", v, 8'h00);
      wr(0, 8'h35); pulse_dot(9'd120, 9'd321, 1'b1, 1'b1);
      cap(v, vl); chk("R6 no clear dot 321", v, 8'h35);
      wr(0, 8'h36); pulse_dot(9'd120, 9'd256, 1'b1, 1'b1);
      cap(v, vl); chk("R6 no clear dot 256", v, 8'h36);
      // host load in the same cycle as the clear
      wr(0, 8'h37);
      @(negedge clk);
      line = 9'd50; dot = 9'd300; show_bg = 1'b1;
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h44;
      @(negedge clk);
      reg_we = 1'b0; reg_sel = 2'd3;
      line = 9'd250; dot = 9'd0; show_bg = 1'b0;
      cap(v, vl); chk("R6 clear beats load", v, 8'h00);
   endtask

   task automatic t_no_clear();
      logic [7:0] v; logic vl;
      wr(0, 8'h51); pulse_dot(9'd5, 9'd300, 1'b0, 1'b0);
      cap(v, vl); chk("R7 forced blank keeps", v, 8'h51);
      wr(0, 8'h52); pulse_dot(9'd250, 9'd300, 1'b1, 1'b1);
      cap(v, vl); chk("R7 vblank line keeps", v, 8'h52);
      wr(0, 8'h53); pulse_dot(9'd240, 9'd260, 1'b1, 1'b1);
      cap(v, vl); chk("R7 line 240 keeps", v, 8'h53);
   endtask

   task automatic t_eval();
      wr(0, 8'h05);
      @(negedge clk); line = 9'd239; dot = 9'd65; show_bg = 1'b1;
      @(posedge clk); #1;
      chk("R8 unaligned index", eval_start, 8'h05);
      chk("R8 pulse", eval_start_vld, 1);
      line = 9'd239; dot = 9'd66;
      @(posedge clk); #1;
      chk("R8 pulse one cycle", eval_start_vld, 0);
      line = 9'd240; dot = 9'd65;
      @(posedge clk); #1;
      chk("R8 no pulse line 240", eval_start_vld, 0);
      chk("R8 index held", eval_start, 8'h05);
      line = 9'd250; dot = 9'd0; show_bg = 1'b0;
   endtask

   task automatic t_copy();
      logic [7:0] v;
      int stalled;
      wr(0, 8'h10);
      wr(2, 8'h37);
      stalled = 1;
      chk("R9 stall raised", cpu_stall, 1);
      chk("R9 first fetch addr", dma_rd_addr, 16'h3700);
      chk("R9 first fetch en", dma_rd_en, 1);
      // host accesses during the copy
      @(negedge clk); reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h99;
      @(posedge clk); #1; reg_we = 1'b0;
      if (cpu_stall) stalled++;
      @(negedge clk); reg_re = 1'b1; reg_sel = 2'd1;
      #1 chk("R10 read while stalled", reg_rdata, 8'h00);
      @(posedge clk); #1; reg_re = 1'b0; reg_sel = 2'd3;
      if (cpu_stall) stalled++;
      while (cpu_stall && stalled < 2000) begin
         @(posedge clk); #1;
         if (cpu_stall) stalled++;
      end
      chk("R9 stall length", stalled, 512);
      rd(v); chk("R11 pointer restored", v, pat(16'h3700));
      wr(0, 8'h11); rd(v); chk("R9 byte 1", v, pat(16'h3701));
      wr(0, 8'hFF); rd(v); chk("R9 byte EF", v, pat(16'h37EF));
      wr(0, 8'h00); rd(v); chk("R9 byte F0", v, pat(16'h37F0));
      wr(0, 8'h0F); rd(v); chk("R10 ignored load / byte FF", v, pat(16'h37FF));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_wrap();
      t_render_read();
      t_clear();
      t_no_clear();
      t_eval();
      t_copy();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule